// File: doc/BRIEF.md
# Condition Register Logical Unit

This block is a small execution unit that owns a 32-bit condition register. The register is divided into eight 4-bit fields. Each field holds one condition code, so eight different producing operations can keep their outcomes side by side. The integer pipes write a whole field with comparison flags on an update port. A separate logical port carries micro-ops that read two single condition bits, combine them with one of eight Boolean functions and write the result into a third bit. The same port can also copy one whole field into another field.

A read port gives branch resolution the registered value of the whole register. It also returns one selected field. Every write takes effect at the clock edge, so a branch sees the effect of an operation in the cycle after that operation is presented. Logical operations read the register value from before the edge. A micro-op whose destination bit is also one of its sources therefore behaves like a plain read-modify-write, and a bit can be inverted by NOR-ing it with itself.

Top module: `cr_logic_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the register clears to all zeros. The first cycle after reset is released shows `br_cr` = 0.
- R2: An update with `upd_valid` high writes `upd_flags` into field `upd_field` at the edge, and `br_cr` shows it in the next cycle. Field f occupies `br_cr[(7-f)*4 +: 4]`, and no other field changes because of the update.
- R3: A logical micro-op (`lop_valid`=1, `lop_copy`=0) writes only the destination bit. The result is f(A,B), where A and B are the source bits read before the edge. The function codes are: 0 AND, 1 OR, 2 XOR, 3 NAND, 4 NOR, 5 EQV (XNOR), 6 A AND NOT B, 7 A OR NOT B.
- R4: A 5-bit condition bit index i selects field i/4 and flag i%4. Its register position is (7-i/4)*4 + i%4. Flag 0 is less-than, flag 1 greater-than, flag 2 equal and flag 3 summary overflow. Field 0 is therefore the most significant nibble.
- R5: Source and destination indices may name the same bit. Sources always read the value from before the edge, so NOR of a bit with itself inverts that bit.
- R6: With `lop_valid`=1 and `lop_copy`=1, the field named by `lop_src_a[4:2]` is copied into the field named by `lop_dst[4:2]`. The copy reads the value from before the edge.
- R7: If an update and a logical op or copy target the same field in one cycle, the update is dropped and only the logical op or copy changes that field. If they target different fields, both take effect.
- R8: `rd_flags` always equals the field of `br_cr` selected by `rd_field`, using the placement given in R2.
- R9: In a cycle with neither `upd_valid` nor `lop_valid`, the register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_valid | input | 1 | Field update from the integer pipes |
| upd_field | input | 3 | Target field of the update |
| upd_flags | input | 4 | Flags to write (LT, GT, EQ, SO from bit 0 upward) |
| lop_valid | input | 1 | Logical micro-op or field copy valid |
| lop_copy | input | 1 | 1 = field copy, 0 = bit logical op |
| lop_func | input | 3 | Boolean function code |
| lop_src_a | input | 5 | First source bit index (its field for a copy) |
| lop_src_b | input | 5 | Second source bit index |
| lop_dst | input | 5 | Destination bit index (its field for a copy) |
| rd_field | input | 3 | Field selected for the read port |
| rd_flags | output | 4 | Selected field value |
| br_cr | output | 32 | Whole registered condition register |

## Verification
Every write lands in the register at one edge and is visible on `br_cr` in the very next cycle. This means a wrong bit position, a wrong function code, a lost update priority or a stale source read shows up as a mismatch in the cycle right after the faulty operation. A corrupted bit stays wrong until something overwrites it, so later logical ops that read it spread the error. A bit-level model in the bench is compared against both outputs after every cycle. The stimulus deliberately forces same-field collisions and cases where the destination bit is also a source bit, so that priority and read-before-write faults surface quickly.

// File: rtl/cr_pkg.sv
// Shared types and index helpers for the condition register unit.
// Assumes the field width is a power of two and field 0 is the top nibble.
package cr_pkg;

    typedef enum logic [2:0] {
        CR_AND  = 3'd0,
        CR_OR   = 3'd1,
        CR_XOR  = 3'd2,
        CR_NAND = 3'd3,
        CR_NOR  = 3'd4,
        CR_EQV  = 3'd5,
        CR_ANDC = 3'd6,
        CR_ORC  = 3'd7
    } cr_func_e;

    // Lowest register position of field f.
    function automatic int field_base(input int f, input int nf, input int fw);
        return (nf - 1 - f) * fw;
    endfunction

    // Register position of condition bit index idx.
    function automatic int bit_pos(input int idx, input int nf, input int fw);
        return field_base(idx / fw, nf, fw) + (idx % fw);
    endfunction

endpackage

// File: rtl/cr_bool_op.sv
// Two-input Boolean function of two condition bits.
// Assumes both inputs are already selected from the pre-edge register.
module cr_bool_op
    import cr_pkg::*;
(
    input  logic     a,
    input  logic     b,
    input  cr_func_e fn,
    output logic     y
);

    // Evaluate the selected function.
    always_comb begin
        unique case (fn)
            CR_AND:  y = a & b;
            CR_OR:   y = a | b;
            CR_XOR:  y = a ^ b;
            CR_NAND: y = ~(a & b);
            CR_NOR:  y = ~(a | b);
            CR_EQV:  y = ~(a ^ b);
            CR_ANDC: y = a & ~b;
            CR_ORC:  y = a | ~b;
            default: y = 1'b0;
        endcase
    end

endmodule

// File: rtl/cr_next_state.sv
// Builds the next condition register value field by field.
// A logical op or copy that targets a field suppresses a same-cycle update of it.
// Assumes FW >= 2 and a power of two.
module cr_next_state #(
    parameter int NFIELD = 8,
    parameter int FW     = 4,
    localparam int CR_W   = NFIELD * FW,
    localparam int IDX_W  = $clog2(CR_W),
    localparam int FSEL_W = $clog2(NFIELD)
) (
    input  logic [CR_W-1:0]   cr_q,
    input  logic              upd_valid,
    input  logic [FSEL_W-1:0] upd_field,
    input  logic [FW-1:0]     upd_flags,
    input  logic              lop_valid,
    input  logic              lop_copy,
    input  logic [IDX_W-1:0]  lop_dst,
    input  logic [FW-1:0]     src_nib,
    input  logic              bit_res,
    output logic [CR_W-1:0]   cr_d
);

    localparam int FB = $clog2(FW);

    logic [FSEL_W-1:0] dst_field;
    logic [FB-1:0]     dst_bit;

    assign dst_field = lop_dst[IDX_W-1:FB];
    assign dst_bit   = lop_dst[FB-1:0];

    for (genvar f = 0; f < NFIELD; f++) begin : g_fld
        localparam int BASE = (NFIELD - 1 - f) * FW;
        logic          lop_hit;
        logic          upd_hit;
        logic [FW-1:0] nxt;

        assign lop_hit = lop_valid && (dst_field == FSEL_W'(f));
        assign upd_hit = upd_valid && (upd_field == FSEL_W'(f)) && !lop_hit;

        // Merge update, copy or single-bit result into this field.
        always_comb begin
            nxt = cr_q[BASE +: FW];
            if (upd_hit) nxt = upd_flags;
            if (lop_hit) begin
                if (lop_copy) nxt = src_nib;
                else          nxt[dst_bit] = bit_res;
            end
        end

        assign cr_d[BASE +: FW] = nxt;
    end

endmodule

// File: rtl/cr_logic_unit.sv
// Condition register logical unit: owns the register, selects source bits,
// and serves the branch read port from the registered value.
// Assumes all indices are in range (true when NFIELD*FW is a power of two).
module cr_logic_unit
    import cr_pkg::*;
#(
    parameter int NFIELD = 8,
    parameter int FW     = 4,
    localparam int CR_W   = NFIELD * FW,
    localparam int IDX_W  = $clog2(CR_W),
    localparam int FSEL_W = $clog2(NFIELD)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_valid,
    input  logic [FSEL_W-1:0] upd_field,
    input  logic [FW-1:0]     upd_flags,
    input  logic              lop_valid,
    input  logic              lop_copy,
    input  logic [2:0]        lop_func,
    input  logic [IDX_W-1:0]  lop_src_a,
    input  logic [IDX_W-1:0]  lop_src_b,
    input  logic [IDX_W-1:0]  lop_dst,
    input  logic [FSEL_W-1:0] rd_field,
    output logic [FW-1:0]     rd_flags,
    output logic [CR_W-1:0]   br_cr
);

    localparam int FB = $clog2(FW);

    logic [CR_W-1:0]  cr_q;
    logic [CR_W-1:0]  cr_d;
    logic [IDX_W-1:0] pos_a;
    logic [IDX_W-1:0] pos_b;
    logic [IDX_W-1:0] src_base;
    logic [IDX_W-1:0] rd_base;
    logic             bit_res;

    assign pos_a    = IDX_W'(bit_pos(int'(lop_src_a), NFIELD, FW));
    assign pos_b    = IDX_W'(bit_pos(int'(lop_src_b), NFIELD, FW));
    assign src_base = IDX_W'(field_base(int'(lop_src_a[IDX_W-1:FB]), NFIELD, FW));
    assign rd_base  = IDX_W'(field_base(int'(rd_field), NFIELD, FW));

    cr_bool_op u_op (
        .a  (cr_q[pos_a]),
        .b  (cr_q[pos_b]),
        .fn (cr_func_e'(lop_func)),
        .y  (bit_res)
    );

    cr_next_state #(.NFIELD(NFIELD), .FW(FW)) u_nxt (
        .cr_q      (cr_q),
        .upd_valid (upd_valid),
        .upd_field (upd_field),
        .upd_flags (upd_flags),
        .lop_valid (lop_valid),
        .lop_copy  (lop_copy),
        .lop_dst   (lop_dst),
        .src_nib   (cr_q[src_base +: FW]),
        .bit_res   (bit_res),
        .cr_d      (cr_d)
    );

    // Hold the condition register; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cr_q <= '0;
        else        cr_q <= cr_d;
    end

    assign br_cr    = cr_q;
    assign rd_flags = cr_q[rd_base +: FW];

endmodule

// File: rtl/cr_logic_unit_chk.sv
// Port-level temporal checks for the condition register unit, bound to the top.
module cr_logic_unit_chk #(
    parameter int NFIELD = 8,
    parameter int FW     = 4,
    localparam int CR_W   = NFIELD * FW,
    localparam int IDX_W  = $clog2(CR_W),
    localparam int FSEL_W = $clog2(NFIELD),
    localparam int FB     = $clog2(FW)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              upd_valid,
    input logic [FSEL_W-1:0] upd_field,
    input logic [FW-1:0]     upd_flags,
    input logic              lop_valid,
    input logic              lop_copy,
    input logic [FSEL_W-1:0] src_field,
    input logic [IDX_W-1:0]  lop_dst,
    input logic [FSEL_W-1:0] rd_field,
    input logic [FW-1:0]     rd_flags,
    input logic [CR_W-1:0]   br_cr
);

    logic [IDX_W-1:0]  upd_base;
    logic [IDX_W-1:0]  dst_base;
    logic [IDX_W-1:0]  src_base;
    logic [IDX_W-1:0]  rd_base;
    logic [FW-1:0]     src_nib;
    logic [CR_W-1:0]   keep_m;
    logic [FSEL_W-1:0] dst_field;

    assign dst_field = lop_dst[IDX_W-1:FB];
    assign upd_base  = IDX_W'((NFIELD - 1 - int'(upd_field)) * FW);
    assign dst_base  = IDX_W'((NFIELD - 1 - int'(dst_field)) * FW);
    assign src_base  = IDX_W'((NFIELD - 1 - int'(src_field)) * FW);
    assign rd_base   = IDX_W'((NFIELD - 1 - int'(rd_field)) * FW);
    assign src_nib   = br_cr[src_base +: FW];

    // Mask of the destination field without the destination bit.
    always_comb begin
        keep_m = '0;
        keep_m[dst_base +: FW] = '1;
        keep_m[dst_base + IDX_W'(lop_dst[FB-1:0])] = 1'b0;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> br_cr == '0);

    // R2
    field_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !(lop_valid && dst_field == upd_field))
        |=> br_cr[$past(upd_base) +: FW] == $past(upd_flags));

    // R6
    field_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lop_valid && lop_copy) |=> br_cr[$past(dst_base) +: FW] == $past(src_nib));

    // R7
    update_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lop_valid && !lop_copy && upd_valid && dst_field == upd_field)
        |=> (br_cr & $past(keep_m)) == ($past(br_cr) & $past(keep_m)));

    // R8
    read_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_flags == br_cr[rd_base +: FW]);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_valid && !lop_valid) |=> $stable(br_cr));

endmodule

bind cr_logic_unit cr_logic_unit_chk #(.NFIELD(NFIELD), .FW(FW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_valid (upd_valid),
    .upd_field (upd_field),
    .upd_flags (upd_flags),
    .lop_valid (lop_valid),
    .lop_copy  (lop_copy),
    .src_field (lop_src_a[IDX_W-1:FB]),
    .lop_dst   (lop_dst),
    .rd_field  (rd_field),
    .rd_flags  (rd_flags),
    .br_cr     (br_cr)
);

// File: tb/sim_cr_logic_unit.sv
`timescale 1ns/1ps
module sim_cr_logic_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_valid = 1'b0;
    logic [2:0]  upd_field = '0;
    logic [3:0]  upd_flags = '0;
    logic        lop_valid = 1'b0;
    logic        lop_copy = 1'b0;
    logic [2:0]  lop_func = '0;
    logic [4:0]  lop_src_a = '0;
    logic [4:0]  lop_src_b = '0;
    logic [4:0]  lop_dst = '0;
    logic [2:0]  rd_field = '0;
    logic [3:0]  rd_flags;
    logic [31:0] br_cr;

    logic [31:0] m_cr = '0;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    cr_logic_unit u0 (
        .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_field(upd_field),
        .upd_flags(upd_flags), .lop_valid(lop_valid), .lop_copy(lop_copy),
        .lop_func(lop_func), .lop_src_a(lop_src_a), .lop_src_b(lop_src_b),
        .lop_dst(lop_dst), .rd_field(rd_field), .rd_flags(rd_flags), .br_cr(br_cr)
    );

    // Register position of a condition bit index (R4 placement).
    function automatic int m_pos(input logic [4:0] i);
        return (7 - int'(i[4:2])) * 4 + int'(i[1:0]);
    endfunction

    // Boolean function table of R3.
    function automatic logic m_fn(input logic [2:0] f, input logic a, input logic b);
        case (f)
            3'd0: return a & b;
            3'd1: return a | b;
            3'd2: return a ^ b;
            3'd3: return ~(a & b);
            3'd4: return ~(a | b);
            3'd5: return ~(a ^ b);
            3'd6: return a & ~b;
            default: return a | ~b;
        endcase
    endfunction

    // Next register value from the currently driven inputs.
    function automatic logic [31:0] m_next(input logic [31:0] c);
        logic [31:0] r = c;
        if (upd_valid && !(lop_valid && lop_dst[4:2] == upd_field))
            r[(7 - int'(upd_field)) * 4 +: 4] = upd_flags;
        if (lop_valid) begin
            if (lop_copy)
                r[(7 - int'(lop_dst[4:2])) * 4 +: 4] = c[(7 - int'(lop_src_a[4:2])) * 4 +: 4];
            else
                r[m_pos(lop_dst)] = m_fn(lop_func, c[m_pos(lop_src_a)], c[m_pos(lop_src_b)]);
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply driven inputs for one edge, then compare both outputs.
    task automatic step(input string tag);
        logic [31:0] e;
        e = m_next(m_cr);
        @(posedge clk);
        @(negedge clk);
        m_cr = e;
        chk(tag, br_cr, m_cr);
        chk("R8", {28'd0, rd_flags}, {28'd0, m_cr[(7 - int'(rd_field)) * 4 +: 4]});
    endtask

    task automatic idle();
        upd_valid = 1'b0;
        lop_valid = 1'b0;
        lop_copy  = 1'b0;
    endtask

    task automatic bitop(input logic [2:0] f, input logic [4:0] a, input logic [4:0] b,
                         input logic [4:0] d);
        lop_valid = 1'b1; lop_copy = 1'b0;
        lop_func = f; lop_src_a = a; lop_src_b = b; lop_dst = d;
    endtask

    initial begin
        string tag;
        void'($urandom(32'd1357));
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1", br_cr, 32'h0);
        chk("R1", {28'd0, rd_flags}, 32'h0);
        rst_n = 1'b1;

        // R4: field 0 is the top nibble, flag 0 its lowest bit
        upd_valid = 1'b1; upd_field = 3'd0; upd_flags = 4'b0001;
        step("R4");
        chk("R4", br_cr, 32'h1000_0000);
        // R2: update field 7
        upd_field = 3'd7; upd_flags = 4'b1010; rd_field = 3'd7;
        step("R2");
        chk("R2", br_cr, 32'h1000_000A);
        idle();
        // R5: invert bit 0 by NOR with itself
        bitop(3'd4, 5'd0, 5'd0, 5'd0);
        step("R5");
        chk("R5", br_cr, 32'h0000_000A);
        // R3: every function on A=0 (bit 0), B=1 (bit 29) into field 2 and 3
        for (int f = 0; f < 8; f++) begin
            bitop(3'(f), 5'd0, 5'd29, 5'(8 + f));
            rd_field = 3'(2 + f / 4);
            step("R3");
        end
        // R3: expected values 0,1,1,1,0,0,0,0 over bits 8..15
        chk("R3", br_cr, 32'h00E0_000A);
        // R6: copy field 7 into field 3
        lop_valid = 1'b1; lop_copy = 1'b1; lop_src_a = 5'd28; lop_dst = 5'd12;
        step("R6");
        chk("R6", br_cr, 32'h00EA_000A);
        // R7: collision in field 2, update dropped
        upd_valid = 1'b1; upd_field = 3'd2; upd_flags = 4'b1111;
        bitop(3'd0, 5'd0, 5'd0, 5'd9);
        step("R7");
        chk("R7", br_cr, 32'h00CA_000A);
        // R7: different fields both apply
        upd_field = 3'd1; upd_flags = 4'b0110;
        bitop(3'd7, 5'd0, 5'd0, 5'd0);
        step("R7");
        chk("R7", br_cr, 32'h16CA_000A);
        // R9: idle cycle
        idle();
        step("R9");
        chk("R9", br_cr, 32'h16CA_000A);

        // Random mix with forced collisions and self-referencing bits
        for (int i = 0; i < 4000; i++) begin
            upd_valid = 1'($urandom_range(0, 1));
            upd_field = 3'($urandom);
            upd_flags = 4'($urandom);
            lop_valid = 1'($urandom_range(0, 1));
            lop_copy  = ($urandom_range(0, 3) == 0);
            lop_func  = 3'($urandom);
            lop_src_a = 5'($urandom);
            lop_src_b = ($urandom_range(0, 3) == 0) ? lop_src_a : 5'($urandom);
            lop_dst   = ($urandom_range(0, 3) == 0) ? {upd_field, 2'($urandom)} : 5'($urandom);
            if ($urandom_range(0, 7) == 0) lop_dst = lop_src_a;
            rd_field  = 3'($urandom);
            if (!upd_valid && !lop_valid) tag = "R9";
            else if (upd_valid && lop_valid && lop_dst[4:2] == upd_field) tag = "R7";
            else if (lop_valid && lop_copy) tag = "R6";
            else if (lop_valid && (lop_dst == lop_src_a || lop_dst == lop_src_b)) tag = "R5";
            else if (lop_valid) tag = "R3";
            else tag = "R2";
            step(tag);
        end
        idle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule